// File: doc/BRIEF.md
# T=0 Command Header Engine

This block runs the card side of the T=0 character protocol once the card is ready for commands. It collects the five command header bytes from the reader and streams them to the host, marked as header bytes. After the fifth byte it turns the line around, switching the receiver off and the transmitter on. It then sends bytes that the host supplies, starting with the procedure byte.

Each host transmit chunk ends with flags. One flag sends the block into data reception. There it forwards exactly as many reader bytes as the fifth header byte (the length byte) announced, in chunks of bounded size. A second flag returns the block to waiting for the next header once the chunk has been sent.

While the block owns the line, an external half-waiting-time pulse makes it send a NULL procedure byte (0x60) ahead of any host data, which holds off the reader. The block pulses a restart output on every byte that passes in either direction, so that the external waiting-time counter starts over.

Top module: `t0_hdr_engine`

## Requirements
- R1: In header-wait mode, each received byte is forwarded on the host stream one cycle later with the header mark set. The five bytes keep the order in which they arrive, and only the fifth carries the chunk-end mark.
- R2: Out of reset, and again in header-wait mode, the receiver enable is high and the transmitter enable is low. Right after the fifth header byte the receiver enable is low and the transmitter enable is high.
- R3: After the fifth header byte, the reported response length equals that byte when it is non-zero and equals 256 when it is zero.
- R4: In transmit mode, when the line is ready and a host byte is offered, that byte appears on the transmit output and the host handshake is asserted in the same cycle.
- R5: When the last byte of a host chunk that carries the continue-with-reception flag has been sent, the block enters receive mode with the receiver enabled and the transmitter disabled. This flag takes priority over the final flag.
- R6: When the last byte of a host chunk marked final (and not flagged for reception) has been sent, the block returns to header-wait mode. A chunk end with neither flag set leaves the block in transmit mode.
- R7: In receive mode, exactly as many data bytes as the length byte gives are forwarded, with the header mark clear. The last of them carries both the chunk-end mark and the final mark, and the block then returns to header-wait mode. A length byte of zero returns the block to header-wait mode directly from the reception-flagged chunk.
- R8: Received data bytes are grouped into chunks of at most CHUNK bytes. Every CHUNK-th byte, and the last byte, carries the chunk-end mark.
- R9: A half-waiting-time pulse in transmit mode causes the byte 0x60 to be sent at the next ready line cycle, before any host byte, with the host handshake low in that cycle. A pulse outside transmit mode has no effect.
- R10: In transmit mode with no host byte offered, nothing is transmitted and the block stays in transmit mode.
- R11: The waiting-time restart output pulses in the same cycle as every byte accepted from the reader and every byte transmitted.
- R12: Bytes that arrive while the transmitter is enabled are not forwarded to the host, do not restart the waiting time, and do not advance header capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received from the reader |
| rx_byte | input | 8 | Received byte |
| wt_half | input | 1 | Half of the waiting time has elapsed |
| tx_ready | input | 1 | Line transmitter can take a byte this cycle |
| htx_valid | input | 1 | Host offers a byte to transmit |
| htx_byte | input | 8 | Host byte to transmit |
| htx_last | input | 1 | Offered byte ends a host chunk |
| htx_to_rx | input | 1 | Chunk flag: continue with data reception |
| htx_final | input | 1 | Chunk flag: command complete |
| htx_ready | output | 1 | Host byte consumed this cycle |
| tx_valid | output | 1 | Byte sent to the line this cycle |
| tx_byte | output | 8 | Byte sent to the line |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| wt_restart | output | 1 | Restart the waiting-time counter |
| hrx_valid | output | 1 | Byte on the host stream |
| hrx_byte | output | 8 | Host stream byte |
| hrx_hdr | output | 1 | Byte belongs to the command header |
| hrx_last | output | 1 | Byte ends a chunk |
| hrx_final | output | 1 | Byte ends the command's receive data |
| resp_len | output | 9 | Card-to-reader byte count derived from the length byte |

## Verification
The assertions take for granted that rx_valid lasts a single cycle per byte. They also assume the host keeps htx_byte and its flags steady while htx_valid waits for the handshake, and that wt_half is a single-cycle pulse. The bench drives every input at the falling edge and raises rx_valid for exactly one cycle per byte. It holds host bytes and flags steady until the cycle in which it checks the handshake, and then drops them. In transmit mode it offers reader bytes only to show that they are ignored.

// File: rtl/t0_hdr_engine.sv
module t0_hdr_engine #(
  parameter int          CHUNK   = 16,
  parameter logic [7:0]  NULL_PB = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       wt_half,
  input  logic       tx_ready,
  input  logic       htx_valid,
  input  logic [7:0] htx_byte,
  input  logic       htx_last,
  input  logic       htx_to_rx,
  input  logic       htx_final,
  output logic       htx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       rx_en,
  output logic       tx_en,
  output logic       wt_restart,
  output logic       hrx_valid,
  output logic [7:0] hrx_byte,
  output logic       hrx_hdr,
  output logic       hrx_last,
  output logic       hrx_final,
  output logic [8:0] resp_len
);
  localparam int CW = $clog2(CHUNK + 1);

  typedef enum logic [1:0] {ST_HDR, ST_TX, ST_RX} st_t;

  st_t           st;
  logic [2:0]    idx;
  logic [7:0]    p3;
  logic [7:0]    rcnt;
  logic [CW-1:0] ccnt;
  logic          null_pend;

  wire in_tx      = (st == ST_TX);
  wire rx_take    = rx_valid && !in_tx;
  wire send_null  = in_tx && tx_ready && null_pend;
  wire send_host  = in_tx && tx_ready && !null_pend && htx_valid;
  wire rx_done    = (st == ST_RX) && (rcnt + 8'd1 == p3);
  wire chunk_full = (int'(ccnt) + 1 == CHUNK);

  assign tx_en      = in_tx;
  assign rx_en      = !in_tx;
  assign tx_valid   = send_null || send_host;
  assign tx_byte    = null_pend ? NULL_PB : htx_byte;
  assign htx_ready  = send_host;
  assign wt_restart = rx_take || tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      idx       <= '0;
      p3        <= '0;
      rcnt      <= '0;
      ccnt      <= '0;
      null_pend <= 1'b0;
      hrx_valid <= 1'b0;
      hrx_byte  <= '0;
      hrx_hdr   <= 1'b0;
      hrx_last  <= 1'b0;
      hrx_final <= 1'b0;
      resp_len  <= '0;
    end else begin
      hrx_valid <= rx_take;
      hrx_hdr   <= 1'b0;
      hrx_last  <= 1'b0;
      hrx_final <= 1'b0;
      if (rx_take) hrx_byte <= rx_byte;
      case (st)
        ST_HDR: begin
          null_pend <= 1'b0;
          if (rx_take) begin
            hrx_hdr <= 1'b1;
            if (idx == 3'd4) begin
              p3       <= rx_byte;
              resp_len <= (rx_byte == 8'd0) ? 9'd256 : {1'b0, rx_byte};
              hrx_last <= 1'b1;
              idx      <= '0;
              st       <= ST_TX;
            end else begin
              idx <= idx + 3'd1;
            end
          end
        end
        ST_TX: begin
          null_pend <= wt_half || (null_pend && !send_null);
          if (send_host && htx_last) begin
            if (htx_to_rx) begin
              null_pend <= 1'b0;
              rcnt      <= '0;
              ccnt      <= '0;
              st        <= (p3 == 8'd0) ? ST_HDR : ST_RX;
            end else if (htx_final) begin
              null_pend <= 1'b0;
              st        <= ST_HDR;
            end
          end
        end
        ST_RX: begin
          null_pend <= 1'b0;
          if (rx_take) begin
            rcnt      <= rcnt + 8'd1;
            ccnt      <= (chunk_full || rx_done) ? '0 : ccnt + 1'b1;
            hrx_last  <= chunk_full || rx_done;
            hrx_final <= rx_done;
            if (rx_done) st <= ST_HDR;
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  a_r1_hdr_follows_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (hrx_valid && hrx_hdr) |-> $past(rx_valid));

  a_r2_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (hrx_valid && hrx_hdr && hrx_last) |-> (tx_en && !rx_en));

  a_r4_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    htx_ready |-> (tx_valid && tx_byte == htx_byte));

  a_r7_final_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (hrx_valid && hrx_final) |-> (rx_en && !tx_en && !hrx_hdr && hrx_last));

  a_r9_null_held: assert property (@(posedge clk) disable iff (!rst_n)
    (null_pend && tx_en && !tx_ready) |=> null_pend);

  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> wt_restart);

  a_r12_no_fwd_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && tx_en) |=> !hrx_valid);
endmodule

// File: tb/sim_t0_hdr_engine.sv
`timescale 1ns/1ps
module sim_t0_hdr_engine;
  localparam int CHUNK = 4;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, wt_half = 0, tx_ready = 0;
  logic htx_valid = 0, htx_last = 0, htx_to_rx = 0, htx_final = 0;
  logic [7:0] rx_byte = 0, htx_byte = 0;
  logic htx_ready, tx_valid, rx_en, tx_en, wt_restart;
  logic hrx_valid, hrx_hdr, hrx_last, hrx_final;
  logic [7:0] tx_byte, hrx_byte;
  logic [8:0] resp_len;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  t0_hdr_engine #(.CHUNK(CHUNK)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wt_half(wt_half), .tx_ready(tx_ready), .htx_valid(htx_valid),
    .htx_byte(htx_byte), .htx_last(htx_last), .htx_to_rx(htx_to_rx),
    .htx_final(htx_final), .htx_ready(htx_ready), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .rx_en(rx_en), .tx_en(tx_en), .wt_restart(wt_restart),
    .hrx_valid(hrx_valid), .hrx_byte(hrx_byte), .hrx_hdr(hrx_hdr),
    .hrx_last(hrx_last), .hrx_final(hrx_final), .resp_len(resp_len));

  // {cla, ins, p1, p2, p3, mode}  mode 0: response sent, 1: data received
  localparam logic [47:0] VEC [5] = '{
    {8'hA0, 8'hB0, 8'h01, 8'h02, 8'h00, 8'h00},
    {8'hA0, 8'hD6, 8'h00, 8'h00, 8'h03, 8'h01},
    {8'h80, 8'hE2, 8'h10, 8'h20, 8'h06, 8'h01},
    {8'h00, 8'hDC, 8'h04, 8'h05, 8'h00, 8'h01},
    {8'hA0, 8'hC0, 8'h00, 8'h00, 8'h09, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic rx_one(input logic [7:0] b, input bit hdr, input bit last,
                        input bit fin, input string req);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    #1 chk("R11 restart on rx", wt_restart, 1);
    @(negedge clk);
    rx_valid = 0;
    chk(req, {hrx_valid, hrx_hdr, hrx_last, hrx_final}, {1'b1, hdr, last, fin});
    chk(req, hrx_byte, b);
  endtask

  task automatic tx_one(input logic [7:0] b, input bit last, input bit to_rx,
                        input bit fin);
    @(negedge clk);
    htx_valid = 1; htx_byte = b; htx_last = last; htx_to_rx = to_rx;
    htx_final = fin; tx_ready = 1;
    #1 chk("R4 host byte sent", {tx_valid, htx_ready, wt_restart, tx_byte},
           {1'b1, 1'b1, 1'b1, b});
    @(negedge clk);
    htx_valid = 0; htx_last = 0; htx_to_rx = 0; htx_final = 0; tx_ready = 0;
  endtask

  task automatic send_hdr(input logic [39:0] h);
    for (int k = 0; k < 5; k++)
      rx_one(h[39-8*k -: 8], 1'b1, k == 4, 1'b0, "R1 header byte");
    chk("R2 turnaround", {tx_en, rx_en}, 2'b10);
    chk("R3 response length", resp_len, (h[7:0] == 0) ? 256 : h[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset state", {rx_en, tx_en, hrx_valid, tx_valid, resp_len},
        {1'b1, 1'b0, 1'b0, 1'b0, 9'd0});
    rst_n = 1;
    @(negedge clk);
    chk("R2 after reset", {rx_en, tx_en}, 2'b10);

    for (int e = 0; e < 5; e++) begin
      logic [47:0] v = VEC[e];
      logic [7:0]  p3 = v[15:8];
      send_hdr(v[47:8]);
      if (v[7:0] == 0) begin
        tx_one(v[39:32], 1'b1, 1'b0, 1'b0);
        chk("R6 chunk end without flags stays in transmit", {tx_en, rx_en}, 2'b10);
        tx_one(8'h90, 1'b0, 1'b0, 1'b0);
        tx_one(8'h00, 1'b1, 1'b0, 1'b1);
        chk("R6 final chunk returns to header wait", {tx_en, rx_en}, 2'b01);
      end else begin
        tx_one(v[39:32], 1'b1, 1'b1, 1'b1);
        chk("R5 receive mode after flagged chunk", {tx_en, rx_en}, 2'b01);
        // R7: zero length returns straight to header wait; next header confirms it
        for (int k = 0; k < int'(p3); k++)
          rx_one(8'hA0 + 8'(k), 1'b0,
                 ((k + 1) % CHUNK == 0) || (k == int'(p3) - 1),
                 k == int'(p3) - 1, "R7 R8 data byte");
      end
    end

    // R9: pulse outside transmit mode is ignored
    @(negedge clk); wt_half = 1;
    @(negedge clk); wt_half = 0;
    send_hdr({8'hA0, 8'hB2, 8'h01, 8'h04, 8'h01});
    tx_one(8'h55, 1'b0, 1'b0, 1'b0);

    // R10: no host data, nothing sent
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); tx_ready = 1;
      #1 chk("R10 idle transmit", {tx_valid, htx_ready, tx_en}, 3'b001);
    end
    @(negedge clk); tx_ready = 0;

    // R12: reader byte while transmitting is dropped
    @(negedge clk); rx_valid = 1; rx_byte = 8'h33;
    #1 chk("R12 no restart in transmit", wt_restart, 0);
    @(negedge clk); rx_valid = 0;
    chk("R12 not forwarded", {hrx_valid, tx_en}, 2'b01);

    // R9: NULL byte goes before the host byte
    @(negedge clk); wt_half = 1; tx_ready = 0;
    @(negedge clk); wt_half = 0;
    htx_valid = 1; htx_byte = 8'h77; htx_last = 1; htx_final = 1; tx_ready = 1;
    #1 chk("R9 null byte", {tx_valid, htx_ready, tx_byte}, {1'b1, 1'b0, 8'h60});
    chk("R11 restart on null", wt_restart, 1);
    @(negedge clk);
    #1 chk("R9 host byte after null", {tx_valid, htx_ready, tx_byte},
           {1'b1, 1'b1, 8'h77});
    @(negedge clk);
    htx_valid = 0; htx_last = 0; htx_final = 0; tx_ready = 0;
    chk("R6 back to header wait", {tx_en, rx_en}, 2'b01);

    // R12: dropped byte did not advance header capture
    send_hdr({8'h11, 8'h22, 8'h33, 8'h44, 8'h05});
    summary();
  end
endmodule